// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block sits beside a processor core and records which of seven interrupt sources have been raised. Each source has a sticky pending flag. A one-cycle post strobe with a 3-bit source code sets a flag. At any moment the block offers the single interrupt the core should take next. The choice depends on the current privilege mode (hypervisor or not), the global interrupt-enable bit, the trap-level-zero enable and the current trap level. It also depends on bit 0 of the hint register that gates timer-compare match, the software-interrupt level register and the processor interrupt level (PIL).

Selection is purely combinational. The valid flag, the cause code and the software-interrupt level appear together in the same cycle as the inputs that produce them. When the core asserts take while valid is high, the pending flags are updated on that clock edge. Software-interrupt levels are handled with care. An interrupt vector takes the place of a low software level. The software pending flag survives a take while other levels remain set in the level register.

Source codes: 0 trap-level-zero, 1 timer-compare match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 software interrupt. Code 7 is invalid.

Top module: `intr_select`

## Requirements
- R1: After reset, no flag is pending: `any_pend_o` and `sel_valid_o` are low and `sel_level_o` is 0.
- R2: A post with a code from 0 to 6 sets that source's flag, and the flag holds until it is taken. `any_pend_o` is high while any flag is set. A post with code 7 raises `post_err_o` in the same cycle and changes no flag.
- R3: In hypervisor mode with interrupts enabled, timer-match (code 1) is selected first, but only when `hint_lsb_i` is 1. The interrupt vector (code 2) is selected next.
- R4: In hypervisor mode with interrupts disabled, nothing is selected, even with timer-match pending and the hint set.
- R5: Outside hypervisor mode, the priority order is fixed regardless of the interrupt-enable bit:
  - trap-level-zero (code 0) is selected first when `tlz_en_i` is 1 and `trap_lvl_i` is 0;
  - timer-match (code 1) is selected next, gated by `hint_lsb_i`.
- R6: Outside hypervisor mode with interrupts enabled, the remaining order is CPU mondo (3), device mondo (4), software interrupt (6) and resumable error (5).
- R7: The software level is the index of the highest set bit of `soft_lvl_i` (bits 1 to 15, bit n meaning level n), or 0 if none is set. With software pending, a level below 6 and the vector pending, the vector (code 2) is selected instead.
- R8: Otherwise the software interrupt is selected only when its level is strictly greater than `pil_i`, and `sel_level_o` then carries that level. `sel_level_o` is 0 whenever the software interrupt is not the selection.
- R9: A take while valid clears the selected source's flag. For the software interrupt, the flag clears only if no bit other than the selected level is set in `soft_lvl_i`.
- R10: When a post and a take hit the same source in the same cycle, the flag stays set.
- R11: A take while `sel_valid_o` is low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| post_i | input | 1 | Post strobe |
| post_src_i | input | 3 | Source code of the post |
| hyp_mode_i | input | 1 | Core is in hypervisor mode |
| int_en_i | input | 1 | Global interrupt enable |
| tlz_en_i | input | 1 | Trap-level-zero interrupt enable |
| trap_lvl_i | input | 3 | Current trap level |
| hint_lsb_i | input | 1 | Bit 0 of the timer hint register |
| soft_lvl_i | input | 15 | Software-interrupt levels 1 to 15 (bits [15:1]) |
| pil_i | input | 4 | Processor interrupt level |
| take_i | input | 1 | Core takes the offered interrupt |
| any_pend_o | output | 1 | At least one flag is set |
| post_err_o | output | 1 | Current post carries an invalid code |
| sel_valid_o | output | 1 | An interrupt is offered |
| sel_cause_o | output | 3 | Source code of the offered interrupt |
| sel_level_o | output | 4 | Software level of the offered interrupt, else 0 |

## Verification
A flag that is wrongly set or cleared in the pending register shows up at the ports within one cycle in two ways:
- `any_pend_o` changes;
- once the mode inputs make that source eligible, a different or missing cause appears on `sel_valid_o` and `sel_cause_o`.

The software flag's survival rule is only visible on a later selection. A wrong clear therefore shows after the next take, when the remaining level should be offered but is not. The bench compares every output on every cycle against a behavioural model. It steers mode, hint, level and PIL inputs so that each flag becomes the top choice at some point.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;
    localparam int NUM_SRC   = 7;
    localparam int CODE_W    = 3;
    localparam int VEC_LVL_LIMIT = 6;

    typedef enum logic [CODE_W-1:0] {
        SRC_TLZ   = 3'd0,
        SRC_TIMER = 3'd1,
        SRC_VEC   = 3'd2,
        SRC_CPUQ  = 3'd3,
        SRC_DEVQ  = 3'd4,
        SRC_RERR  = 3'd5,
        SRC_SOFT  = 3'd6
    } src_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } pend_st_t;
endpackage

// File: rtl/intr_soft_enc.sv
module intr_soft_enc
    import intr_sel_pkg::*;
#(
    parameter int SOFT_W = 16,
    localparam int LW = $clog2(SOFT_W)
) (
    input  logic [SOFT_W-1:1] bits_i,
    output logic [LW-1:0]     lvl_o,
    output logic              others_o
);
    logic [LW-1:0] lvl_d;
    logic          others_d;

    always_comb begin
        lvl_d = '0;
        for (int i = 1; i < SOFT_W; i++) begin
            if (bits_i[i]) lvl_d = LW'(i);
        end
        others_d = 1'b0;
        for (int i = 1; i < SOFT_W; i++) begin
            if (bits_i[i] && (LW'(i) != lvl_d)) others_d = 1'b1;
        end
    end

    assign lvl_o    = lvl_d;
    assign others_o = others_d;
endmodule

// File: rtl/intr_arb.sv
module intr_arb
    import intr_sel_pkg::*;
#(
    parameter int LW  = 4,
    parameter int TLW = 3
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               hyp_i,
    input  logic               ie_i,
    input  logic               tlz_en_i,
    input  logic [TLW-1:0]     tl_i,
    input  logic               hint_i,
    input  logic [LW-1:0]      lvl_i,
    input  logic [LW-1:0]      pil_i,
    output logic               valid_o,
    output src_e               cause_o,
    output logic [LW-1:0]      level_o
);
    logic soft_low;
    logic timer_ok;

    assign soft_low = (lvl_i < LW'(VEC_LVL_LIMIT));
    assign timer_ok = pend_i[SRC_TIMER] && hint_i;

    always_comb begin
        valid_o = 1'b0;
        cause_o = SRC_TLZ;
        level_o = '0;
        if (hyp_i) begin
            if (ie_i) begin
                if (timer_ok) begin
                    valid_o = 1'b1;
                    cause_o = SRC_TIMER;
                end else if (pend_i[SRC_VEC]) begin
                    valid_o = 1'b1;
                    cause_o = SRC_VEC;
                end
            end
        end else begin
            if (pend_i[SRC_TLZ] && tlz_en_i && (tl_i == '0)) begin
                valid_o = 1'b1;
                cause_o = SRC_TLZ;
            end else if (timer_ok) begin
                valid_o = 1'b1;
                cause_o = SRC_TIMER;
            end else if (ie_i) begin
                if (pend_i[SRC_CPUQ]) begin
                    valid_o = 1'b1;
                    cause_o = SRC_CPUQ;
                end else if (pend_i[SRC_DEVQ]) begin
                    valid_o = 1'b1;
                    cause_o = SRC_DEVQ;
                end else if (pend_i[SRC_SOFT] && soft_low && pend_i[SRC_VEC]) begin
                    valid_o = 1'b1;
                    cause_o = SRC_VEC;
                end else if (pend_i[SRC_SOFT] && (lvl_i > pil_i)) begin
                    valid_o = 1'b1;
                    cause_o = SRC_SOFT;
                    level_o = lvl_i;
                end else if (pend_i[SRC_RERR]) begin
                    valid_o = 1'b1;
                    cause_o = SRC_RERR;
                end
            end
        end
    end
endmodule

// File: rtl/intr_pend_reg.sv
module intr_pend_reg
    import intr_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_i,
    input  logic [CODE_W-1:0]  post_src_i,
    input  logic               take_i,
    input  logic               sel_valid_i,
    input  logic [CODE_W-1:0]  sel_cause_i,
    input  logic               soft_keep_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               post_err_o
);
    pend_st_t st_d, st_q;
    logic     bad_code;

    always_comb begin
        st_d     = st_q;
        bad_code = post_i && (post_src_i >= CODE_W'(NUM_SRC));
        if (take_i && sel_valid_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sel_cause_i == CODE_W'(i)) begin
                    if (!((i == int'(SRC_SOFT)) && soft_keep_i)) st_d.pend[i] = 1'b0;
                end
            end
        end
        if (post_i && !bad_code) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (post_src_i == CODE_W'(i)) st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o     = st_q.pend;
    assign post_err_o = bad_code;
endmodule

// File: rtl/intr_select.sv
module intr_select
    import intr_sel_pkg::*;
#(
    parameter int SOFT_W = 16,
    parameter int TL_W   = 3,
    localparam int LVL_W = $clog2(SOFT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_i,
    input  logic [2:0]        post_src_i,
    input  logic              hyp_mode_i,
    input  logic              int_en_i,
    input  logic              tlz_en_i,
    input  logic [TL_W-1:0]   trap_lvl_i,
    input  logic              hint_lsb_i,
    input  logic [SOFT_W-1:1] soft_lvl_i,
    input  logic [LVL_W-1:0]  pil_i,
    input  logic              take_i,
    output logic              any_pend_o,
    output logic              post_err_o,
    output logic              sel_valid_o,
    output logic [2:0]        sel_cause_o,
    output logic [LVL_W-1:0]  sel_level_o
);
    logic [NUM_SRC-1:0] pend_w;
    logic [LVL_W-1:0]   lvl_w;
    logic               others_w;
    logic               valid_w;
    src_e               cause_w;
    logic [LVL_W-1:0]   level_w;

    intr_soft_enc #(.SOFT_W(SOFT_W)) u_enc (
        .bits_i  (soft_lvl_i),
        .lvl_o   (lvl_w),
        .others_o(others_w)
    );

    intr_arb #(.LW(LVL_W), .TLW(TL_W)) u_arb (
        .pend_i  (pend_w),
        .hyp_i   (hyp_mode_i),
        .ie_i    (int_en_i),
        .tlz_en_i(tlz_en_i),
        .tl_i    (trap_lvl_i),
        .hint_i  (hint_lsb_i),
        .lvl_i   (lvl_w),
        .pil_i   (pil_i),
        .valid_o (valid_w),
        .cause_o (cause_w),
        .level_o (level_w)
    );

    intr_pend_reg u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_i     (post_i),
        .post_src_i (post_src_i),
        .take_i     (take_i),
        .sel_valid_i(valid_w),
        .sel_cause_i(cause_w),
        .soft_keep_i(others_w),
        .pend_o     (pend_w),
        .post_err_o (post_err_o)
    );

    assign any_pend_o  = |pend_w;
    assign sel_valid_o = valid_w;
    assign sel_cause_o = cause_w;
    assign sel_level_o = level_w;
endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk
    import intr_sel_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_i,
    input logic [2:0]         post_src_i,
    input logic               hyp_mode_i,
    input logic               int_en_i,
    input logic               take_i,
    input logic [LVL_W-1:0]   pil_i,
    input logic               post_err_o,
    input logic               sel_valid_o,
    input logic [2:0]         sel_cause_o,
    input logic [LVL_W-1:0]   sel_level_o,
    input logic [NUM_SRC-1:0] pend
);
    // R4
    hyp_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hyp_mode_i && !int_en_i) |-> !sel_valid_o);

    // R8
    soft_above_pil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && sel_cause_o == SRC_SOFT) |-> (sel_level_o > pil_i));

    // R8
    level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_valid_o && sel_cause_o == SRC_SOFT) |-> (sel_level_o == '0));

    // R2
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_i && !post_err_o) |=> (((pend >> $past(post_src_i)) & 7'd1) != 7'd0));

    // R2
    bad_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_err_o && !take_i) |=> $stable(pend));

    // R11
    idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid_o && !post_i) |=> $stable(pend));

    // R9
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && sel_valid_o && sel_cause_o != SRC_SOFT &&
         !(post_i && post_src_i == sel_cause_o))
        |=> (((pend >> $past(sel_cause_o)) & 7'd1) == 7'd0));

    // R6
    offered_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (pend != '0));
endmodule

bind intr_select intr_select_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_i     (post_i),
    .post_src_i (post_src_i),
    .hyp_mode_i (hyp_mode_i),
    .int_en_i   (int_en_i),
    .take_i     (take_i),
    .pil_i      (pil_i),
    .post_err_o (post_err_o),
    .sel_valid_o(sel_valid_o),
    .sel_cause_o(sel_cause_o),
    .sel_level_o(sel_level_o),
    .pend       (pend_w)
);

// File: tb/intr_select_tb.sv
module intr_select_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_i = 1'b0;
    logic [2:0]  post_src_i = '0;
    logic        hyp_mode_i = 1'b0;
    logic        int_en_i = 1'b0;
    logic        tlz_en_i = 1'b0;
    logic [2:0]  trap_lvl_i = '0;
    logic        hint_lsb_i = 1'b0;
    logic [15:1] soft_lvl_i = '0;
    logic [3:0]  pil_i = '0;
    logic        take_i = 1'b0;
    logic        any_pend_o, post_err_o, sel_valid_o;
    logic [2:0]  sel_cause_o;
    logic [3:0]  sel_level_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit m_pend [7];
    bit e_valid, e_any, e_err;
    int e_cause, e_level;

    always #10 clk = ~clk;

    intr_select u_dut (
        .clk(clk), .rst_n(rst_n), .post_i(post_i), .post_src_i(post_src_i),
        .hyp_mode_i(hyp_mode_i), .int_en_i(int_en_i), .tlz_en_i(tlz_en_i),
        .trap_lvl_i(trap_lvl_i), .hint_lsb_i(hint_lsb_i), .soft_lvl_i(soft_lvl_i),
        .pil_i(pil_i), .take_i(take_i), .any_pend_o(any_pend_o),
        .post_err_o(post_err_o), .sel_valid_o(sel_valid_o),
        .sel_cause_o(sel_cause_o), .sel_level_o(sel_level_o)
    );

    function automatic int top_level();
        int l = 0;
        for (int b = 15; b >= 1; b--) if (soft_lvl_i[b] && l == 0) l = b;
        return l;
    endfunction

    task automatic pick(int c, int l);
        e_valid = 1'b1;
        e_cause = c;
        e_level = l;
    endtask

    task automatic model_eval();
        int lv = top_level();
        e_valid = 1'b0; e_cause = 0; e_level = 0;
        e_any = 1'b0;
        for (int k = 0; k < 7; k++) if (m_pend[k]) e_any = 1'b1;
        e_err = post_i && (post_src_i == 3'd7);
        if (hyp_mode_i) begin
            if (int_en_i && m_pend[1] && hint_lsb_i) pick(1, 0);
            else if (int_en_i && m_pend[2]) pick(2, 0);
        end else if (m_pend[0] && tlz_en_i && trap_lvl_i == 0) pick(0, 0);
        else if (m_pend[1] && hint_lsb_i) pick(1, 0);
        else if (int_en_i) begin
            if (m_pend[3]) pick(3, 0);
            else if (m_pend[4]) pick(4, 0);
            else if (m_pend[6] && lv < 6 && m_pend[2]) pick(2, 0);
            else if (m_pend[6] && lv > int'(pil_i)) pick(6, lv);
            else if (m_pend[5]) pick(5, 0);
        end
    endtask

    task automatic model_update();
        if (take_i && e_valid) begin
            if (e_cause == 6) begin
                int rest = 0;
                for (int b = 1; b <= 15; b++) if (soft_lvl_i[b] && b != e_level) rest++;
                if (rest == 0) m_pend[6] = 1'b0;
            end else m_pend[e_cause] = 1'b0;
        end
        if (post_i && post_src_i != 3'd7) m_pend[post_src_i] = 1'b1;
    endtask

    // compare outputs mid-cycle, then advance one clock
    task automatic step(string tag);
        #5;
        model_eval();
        checks++;
        if (any_pend_o !== e_any || post_err_o !== e_err || sel_valid_o !== e_valid ||
            (e_valid && (int'(sel_cause_o) != e_cause)) || int'(sel_level_o) != e_level) begin
            fails++;
            $display("FAIL %s: any=%0b err=%0b valid=%0b cause=%0d level=%0d expected any=%0b err=%0b valid=%0b cause=%0d level=%0d",
                     tag, any_pend_o, post_err_o, sel_valid_o, sel_cause_o, sel_level_o,
                     e_any, e_err, e_valid, e_cause, e_level);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        post_i = 1'b0;
        take_i = 1'b0;
    endtask

    task automatic post(int s);
        post_i = 1'b1;
        post_src_i = 3'(s);
    endtask

    task automatic mode(bit h, bit ie, bit tz, int tl, bit hint, int pil);
        hyp_mode_i = h; int_en_i = ie; tlz_en_i = tz;
        trap_lvl_i = 3'(tl); hint_lsb_i = hint; pil_i = 4'(pil);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 7; k++) m_pend[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset state");

        // R2 posting, sticky flags, invalid code
        mode(0, 0, 0, 1, 0, 15);
        post(5); step("R2 post rerr");
        step("R2 flag sticky");
        post(7); step("R2 invalid code");
        step("R2 invalid post left flags");

        // R3 hypervisor with enable
        post(1); step("R2 post timer");
        post(2); step("R2 post vector");
        mode(1, 1, 0, 1, 1, 0); step("R3 timer first");
        mode(1, 1, 0, 1, 0, 0); step("R3 hint gates timer");
        // R4 hypervisor without enable
        mode(1, 0, 0, 1, 1, 0); step("R4 masked");
        take_i = 1'b1; step("R11 take without valid");
        step("R11 flags unchanged");
        mode(1, 1, 0, 1, 1, 0);
        take_i = 1'b1; step("R9 take timer");
        take_i = 1'b1; step("R9 take vector");
        step("R3 nothing left in hyp");

        // R5 non-hypervisor ordering, independent of enable
        post(0); step("R2 post tlz");
        post(1); step("R2 post timer again");
        mode(0, 0, 1, 0, 1, 0); step("R5 tlz first");
        mode(0, 0, 1, 2, 1, 0); step("R5 timer when trap level nonzero");
        mode(0, 0, 0, 0, 1, 0); step("R5 tlz enable off");
        take_i = 1'b1; step("R9 take timer outside hyp");
        mode(0, 0, 1, 0, 0, 0);
        take_i = 1'b1; step("R9 take tlz");

        // R6 ordering with enable
        post(3); step("R6 post cpu");
        post(4); step("R6 post dev");
        soft_lvl_i = 15'h0;
        soft_lvl_i[9] = 1'b1;
        post(6); step("R6 post soft");
        mode(0, 1, 0, 1, 0, 2);
        take_i = 1'b1; step("R6 cpu first");
        take_i = 1'b1; step("R6 dev second");
        step("R6 soft before rerr");
        pil_i = 4'd9; step("R8 level equal pil gives rerr");
        take_i = 1'b1; step("R9 take rerr");
        pil_i = 4'd2;

        // R7 vector replaces low software level
        post(2); step("R7 post vector");
        soft_lvl_i[9] = 1'b0; soft_lvl_i[3] = 1'b1; step("R7 vector over level 3");
        soft_lvl_i[5] = 1'b1; step("R7 vector over level 5");
        soft_lvl_i[6] = 1'b1; step("R7 level 6 beats vector");
        soft_lvl_i = '0; soft_lvl_i[3] = 1'b1;
        take_i = 1'b1; step("R7 take vector in soft slot");
        step("R8 level 3 above pil 2");
        pil_i = 4'd3; step("R8 level 3 not above pil 3");
        soft_lvl_i = '0; step("R7 empty register gives level 0");

        // R9 soft flag survives while other levels remain
        pil_i = 4'd0;
        soft_lvl_i[12] = 1'b1; soft_lvl_i[4] = 1'b1;
        take_i = 1'b1; step("R9 take level 12 keeps flag");
        soft_lvl_i[12] = 1'b0; step("R9 level 4 now offered");
        take_i = 1'b1; step("R9 take last level clears");
        step("R9 soft flag gone");

        // R10 post and take on same source
        post(3); step("R10 post cpu");
        post(3); take_i = 1'b1; step("R10 post and take together");
        step("R10 flag kept");
        take_i = 1'b1; step("R10 final take");
        step("R10 empty");

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            mode(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                 int'($urandom_range(0, 1)), 1'($urandom), int'($urandom_range(0, 15)));
            soft_lvl_i = 15'($urandom);
            if ($urandom_range(0, 2) == 0) soft_lvl_i = '0;
            if ($urandom_range(0, 1) == 0) post(int'($urandom_range(0, 7)));
            take_i = 1'($urandom);
            step("R6 mixed traffic");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule